// File: doc/BRIEF.md
# Transmitter power-mode and fail-safe controller

This block sequences a radio transmitter through four operating modes: power-down, oscillator active, PLL standby and transmitter active. The enable line wakes the block. A PLL-enable bit, together with an oscillator-ready timer, moves it into standby. The transmitter mode is reached only through an explicit one-byte transmit command. The fields of that command are latched on entry. They choose the frequency channel, the modulation-control set, the synchronous/Manchester options and the enable-fall behaviour.

The power amplifier is switched on only after the synthesizer settling timer reports done. The analog detectors are plain inputs: PLL loss of lock, VCO calibration error, undervoltage and oscillator amplitude. Their results are held as sticky flags. Any error flag stops the amplifier unless the fail-safe disable input is set. A 4-bit counter records how many times the transmitter mode has been entered.

Top module: `tx_mode_ctrl`

## Requirements
- R1: `mode_o` encodes 0 = power-down, 1 = oscillator active, 2 = PLL standby, 3 = transmitter active, and resets to 0. A rising edge of `en_i` in power-down gives mode 1 one cycle later. `en_i` low in mode 1 or 2 gives mode 0 one cycle later.
- R2: In mode 1, `osc_ready_i` with `pll_en_i` high moves to mode 2 on the next cycle. In mode 2, `pll_en_i` low returns to mode 1. Without `pll_en_i` the block stays in mode 1.
- R3: `pa_en_o` is high only in mode 3. It stays low after entry until `settle_done_i` has been seen in mode 3, and then rises one cycle after that sample.
- R4: Command byte layout: bit0 synchronous, bit1 stop on enable fall, bit2 Manchester, bit3 modulation-set select, bits 5:4 channel, bits 7:6 reserved. A command with bit2 set and bit0 clear, or with nonzero reserved bits, is rejected. The fields of an accepted command appear on the outputs one cycle after `cmd_valid_i`, together with mode 3.
- R5: `tx_count_o` increments on each entry into mode 3 and wraps from 15 to 0. It resets to 0.
- R6: `status_o` bit0 is PLL loss of lock, bit1 is VCO calibration error, bit2 is undervoltage, and bit3 is `osc_amp_ok_i` registered one cycle.
- R7: With `fs_disable_i` low, any set error flag (bits 2:0) forces `pa_en_o` low. With `fs_disable_i` high, the amplifier keeps running after an error.
- R8: An error flag sets one cycle after its input is high, outside power-down. It stays set until `clr_i`. A set request wins over `clr_i` in the same cycle.
- R9: The undervoltage flag reads 0 in every cycle that follows a cycle spent in power-down. No error flag is set while in power-down.
- R10: A command received outside mode 2 is ignored: the mode, the latched fields and the counter do not change.
- R11: In mode 3, a falling `en_i` returns to mode 2 when the latched stop bit is set. When the stop bit is clear, the block stays in mode 3 and the amplifier keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable line |
| pll_en_i | input | 1 | PLL-enable register bit |
| osc_ready_i | input | 1 | Oscillator start-up time elapsed |
| settle_done_i | input | 1 | Synthesizer settling time elapsed |
| cmd_valid_i | input | 1 | Transmit command strobe |
| cmd_i | input | 8 | Transmit command byte |
| fs_disable_i | input | 1 | Fail-safe disable |
| clr_i | input | 1 | Write-clear of error flags |
| lol_i | input | 1 | PLL loss-of-lock detector |
| vco_err_i | input | 1 | VCO calibration error detector |
| uv_i | input | 1 | Undervoltage detector |
| osc_amp_ok_i | input | 1 | Oscillator amplitude sufficient |
| mode_o | output | 2 | Current mode |
| pa_en_o | output | 1 | Power amplifier enable |
| chan_o | output | 2 | Selected frequency channel |
| mod_set_o | output | 1 | Modulation-control set select |
| sync_o | output | 1 | Synchronous transmission |
| manch_o | output | 1 | Manchester coding |
| stop_on_fall_o | output | 1 | Amplifier stops on enable fall |
| status_o | output | 4 | Status flags |
| tx_count_o | output | 4 | Transmitter-entry counter |

## Verification
The assertions assume that the reset is released away from a clock edge. They also assume that every input is a synchronous level or pulse that is stable around the sampling edge. No timing relation between the detector inputs and the modes is assumed. The stimulus drives all inputs on the falling clock edge only, and reset is released on a falling edge. Directed phases walk each mode transition and command corner. A random phase then draws every input with biases, so that mode 3, errors and clears all recur.

// File: rtl/tx_mode_pkg.sv
package tx_mode_pkg;
  typedef enum logic [1:0] {
    MODE_PD   = 2'd0,
    MODE_OSC  = 2'd1,
    MODE_STBY = 2'd2,
    MODE_TX   = 2'd3
  } mode_e;

  localparam int CHAN_W = 2;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              set_sel;
    logic              manch;
    logic              stop_on_fall;
    logic              sync;
  } cmd_t;

  localparam int CMD_FIELD_W = $bits(cmd_t);
endpackage

// File: rtl/tx_cmd_decode.sv
module tx_cmd_decode
  import tx_mode_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_t             fields_o,
  output logic             ok_o
);
  localparam int RSV_W = CMD_W - CMD_FIELD_W;

  assign fields_o = cmd_t'(cmd_i[CMD_FIELD_W-1:0]);

  logic rsv_clean;
  generate
    if (RSV_W > 0) begin : g_rsv
      assign rsv_clean = (cmd_i[CMD_W-1:CMD_FIELD_W] == '0);
    end else begin : g_no_rsv
      assign rsv_clean = 1'b1;
    end
  endgenerate

  // Manchester coding is only legal with synchronous transmission
  assign ok_o = rsv_clean && !(fields_o.manch && !fields_o.sync);
endmodule

// File: rtl/tx_mode_fsm.sv
module tx_mode_fsm
  import tx_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  pll_en_i,
  input  logic  osc_ready_i,
  input  logic  settle_done_i,
  input  logic  go_i,
  input  cmd_t  fields_i,
  output mode_e mode_o,
  output logic  enter_tx_o,
  output logic  settled_o,
  output cmd_t  cmd_o
);
  mode_e mode_q, mode_d;
  logic  en_q, settled_q;
  cmd_t  cmd_q;
  logic  en_rise, en_fall;

  assign en_rise = en_i && !en_q;
  assign en_fall = !en_i && en_q;

  always_comb begin
    mode_d     = mode_q;
    enter_tx_o = 1'b0;
    unique case (mode_q)
      MODE_PD:   if (en_rise) mode_d = MODE_OSC;
      MODE_OSC: begin
        if (!en_i) mode_d = MODE_PD;
        else if (osc_ready_i && pll_en_i) mode_d = MODE_STBY;
      end
      MODE_STBY: begin
        if (!en_i) mode_d = MODE_PD;
        else if (!pll_en_i) mode_d = MODE_OSC;
        else if (go_i) begin
          mode_d     = MODE_TX;
          enter_tx_o = 1'b1;
        end
      end
      MODE_TX:   if (en_fall && cmd_q.stop_on_fall) mode_d = MODE_STBY;
      default:   mode_d = MODE_PD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_PD;
      en_q      <= 1'b0;
      settled_q <= 1'b0;
      cmd_q     <= '0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_i;
      if (enter_tx_o) begin
        settled_q <= 1'b0;
        cmd_q     <= fields_i;
      end else if (mode_q == MODE_TX && settle_done_i) begin
        settled_q <= 1'b1;
      end
    end
  end

  assign mode_o    = mode_q;
  assign settled_o = settled_q;
  assign cmd_o     = cmd_q;
endmodule

// File: rtl/tx_status_flags.sv
module tx_status_flags
  import tx_mode_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             enter_tx_i,
  input  logic             clr_i,
  input  logic             lol_i,
  input  logic             vco_err_i,
  input  logic             uv_i,
  input  logic             osc_amp_ok_i,
  output logic [2:0]       err_o,
  output logic             amp_ok_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int N_ERR = 3;

  logic [N_ERR-1:0] err_q, err_in;
  logic             awake;

  assign err_in = {uv_i, vco_err_i, lol_i};
  assign awake  = (mode_i != MODE_PD);

  for (genvar i = 0; i < N_ERR; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    err_q[i] <= 1'b0;
      else if (i == 2 && !awake)      err_q[i] <= 1'b0;  // power-down clears undervoltage
      else if (awake && err_in[i])    err_q[i] <= 1'b1;
      else if (clr_i)                 err_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amp_ok_o <= 1'b0;
      count_o  <= '0;
    end else begin
      amp_ok_o <= osc_amp_ok_i;
      if (enter_tx_i) count_o <= count_o + 1'b1;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/tx_mode_ctrl.sv
module tx_mode_ctrl
  import tx_mode_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pll_en_i,
  input  logic             osc_ready_i,
  input  logic             settle_done_i,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             fs_disable_i,
  input  logic             clr_i,
  input  logic             lol_i,
  input  logic             vco_err_i,
  input  logic             uv_i,
  input  logic             osc_amp_ok_i,
  output logic [1:0]       mode_o,
  output logic             pa_en_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic             mod_set_o,
  output logic             sync_o,
  output logic             manch_o,
  output logic             stop_on_fall_o,
  output logic [3:0]       status_o,
  output logic [CNT_W-1:0] tx_count_o
);
  cmd_t       fields, cmd_q;
  logic       cmd_ok, enter_tx, settled, amp_ok;
  mode_e      mode;
  logic [2:0] err;

  tx_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .cmd_i    (cmd_i),
    .fields_o (fields),
    .ok_o     (cmd_ok)
  );

  tx_mode_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .pll_en_i      (pll_en_i),
    .osc_ready_i   (osc_ready_i),
    .settle_done_i (settle_done_i),
    .go_i          (cmd_valid_i && cmd_ok),
    .fields_i      (fields),
    .mode_o        (mode),
    .enter_tx_o    (enter_tx),
    .settled_o     (settled),
    .cmd_o         (cmd_q)
  );

  tx_status_flags #(.CNT_W(CNT_W)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode),
    .enter_tx_i   (enter_tx),
    .clr_i        (clr_i),
    .lol_i        (lol_i),
    .vco_err_i    (vco_err_i),
    .uv_i         (uv_i),
    .osc_amp_ok_i (osc_amp_ok_i),
    .err_o        (err),
    .amp_ok_o     (amp_ok),
    .count_o      (tx_count_o)
  );

  assign mode_o         = mode;
  assign pa_en_o        = (mode == MODE_TX) && settled && (fs_disable_i || (err == '0));
  assign chan_o         = cmd_q.chan;
  assign mod_set_o      = cmd_q.set_sel;
  assign sync_o         = cmd_q.sync;
  assign manch_o        = cmd_q.manch;
  assign stop_on_fall_o = cmd_q.stop_on_fall;
  assign status_o       = {amp_ok, err};
endmodule

// File: rtl/tx_mode_ctrl_chk.sv
module tx_mode_ctrl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             pll_en_i,
  input logic             cmd_valid_i,
  input logic             fs_disable_i,
  input logic             clr_i,
  input logic [1:0]       mode_o,
  input logic             pa_en_o,
  input logic [3:0]       status_o,
  input logic [CNT_W-1:0] tx_count_o
);
  p_pd_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && !en_i) |=> (mode_o == 2'd0));

  p_no_stby_without_pll_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && !pll_en_i) |=> (mode_o != 2'd2));

  p_pa_only_tx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_en_o |-> (mode_o == 2'd3));

  p_pa_off_on_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd3) |=> !pa_en_o);

  p_count_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd3) ##1 (mode_o == 2'd3) |-> (tx_count_o == CNT_W'($past(tx_count_o) + 1'b1)));

  p_failsafe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o[2:0] != 3'b000) && !fs_disable_i) |-> !pa_en_o);

  p_sticky_lol_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !clr_i) |=> status_o[0]);

  p_uv_pd_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0) |=> !status_o[2]);

  p_cmd_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && mode_o != 2'd2) |=> $stable(tx_count_o));
endmodule

bind tx_mode_ctrl tx_mode_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tx_mode_ctrl_bench.sv
`timescale 1ns/1ps
module tx_mode_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, pll_en = 0, osc_rdy = 0, settle = 0, cmd_v = 0, fs_dis = 0, clr = 0;
  logic lol = 0, vco = 0, uv = 0, amp = 0;
  logic [7:0] cmd = 8'h00;
  logic [1:0] mode_o, chan_o;
  logic pa_o, set_o, sync_o, manch_o, stop_o;
  logic [3:0] status_o, count_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_mode_ctrl u_tx_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pll_en_i(pll_en), .osc_ready_i(osc_rdy),
    .settle_done_i(settle), .cmd_valid_i(cmd_v), .cmd_i(cmd), .fs_disable_i(fs_dis),
    .clr_i(clr), .lol_i(lol), .vco_err_i(vco), .uv_i(uv), .osc_amp_ok_i(amp),
    .mode_o(mode_o), .pa_en_o(pa_o), .chan_o(chan_o), .mod_set_o(set_o), .sync_o(sync_o),
    .manch_o(manch_o), .stop_on_fall_o(stop_o), .status_o(status_o), .tx_count_o(count_o)
  );

  // behavioural reference
  int m_mode, m_cnt;
  bit m_en_q, m_settled, m_lol, m_vco, m_uv, m_amp;
  bit [5:0] m_cmd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_en_q = 0; m_settled = 0;
      m_lol = 0; m_vco = 0; m_uv = 0; m_amp = 0; m_cmd = 0;
    end else begin
      int nm;
      bit ok, go;
      nm = m_mode; go = 0;
      ok = (cmd[7:6] == 2'b00) && !(cmd[2] && !cmd[0]);
      if (m_mode == 0) begin
        if (en && !m_en_q) nm = 1;
      end else if (m_mode == 1) begin
        if (!en) nm = 0; else if (osc_rdy && pll_en) nm = 2;
      end else if (m_mode == 2) begin
        if (!en) nm = 0; else if (!pll_en) nm = 1;
        else if (cmd_v && ok) begin nm = 3; go = 1; end
      end else begin
        if (!en && m_en_q && m_cmd[1]) nm = 2;
      end
      if (m_mode == 0) m_uv = 0;
      else if (uv) m_uv = 1;
      else if (clr) m_uv = 0;
      if (m_mode != 0 && lol) m_lol = 1; else if (clr) m_lol = 0;
      if (m_mode != 0 && vco) m_vco = 1; else if (clr) m_vco = 0;
      m_amp = amp;
      if (go) begin m_cmd = cmd[5:0]; m_cnt = (m_cnt + 1) % 16; m_settled = 0; end
      else if (m_mode == 3 && settle) m_settled = 1;
      m_mode = nm; m_en_q = en;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit m_pa;
    m_pa = (m_mode == 3) && m_settled && (fs_dis || !(m_lol || m_vco || m_uv));
    check("R1 mode", mode_o, m_mode);
    check("R3 pa_en", pa_o, m_pa);
    check("R4 fields", {chan_o, set_o, manch_o, stop_o, sync_o}, m_cmd);
    check("R5 count", count_o, m_cnt);
    check("R6 status", status_o, {m_amp, m_uv, m_vco, m_lol});
  endtask

  // one cycle: compare at falling edge, then the caller drives
  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    {en, pll_en, osc_rdy, settle, cmd_v, fs_dis, clr, lol, vco, uv, amp} = '0;
    cmd = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic to_stby();
    en = 1; step(1); check("R1 wake", mode_o, 1);
    osc_rdy = 1; step(1); check("R2 no pll", mode_o, 1);
    pll_en = 1; step(1); check("R2 stby", mode_o, 2);
    osc_rdy = 0;
  endtask

  task automatic send(logic [7:0] c);
    cmd = c; cmd_v = 1; step(1); cmd_v = 0; cmd = 0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1;
    step(2);
    rst_n = 1;
    step(1);
    check("R1 reset mode", mode_o, 0);
    check("R5 reset count", count_o, 0);

    // R1/R2 walk into standby
    to_stby();
    pll_en = 0; step(1); check("R2 pll off", mode_o, 1);
    pll_en = 1; osc_rdy = 1; step(1); osc_rdy = 0; check("R2 back", mode_o, 2);

    // R4 rejected commands
    send(8'h04); check("R4 manch w/o sync", mode_o, 2);
    send(8'h41); check("R4 reserved", count_o, 0);
    // accepted: sync, manch, set1, chan3
    send(8'h3D);
    check("R4 enter", mode_o, 3); check("R4 chan", chan_o, 3); check("R4 set", set_o, 1);
    check("R3 pa low pre-settle", pa_o, 0);
    step(3); check("R3 still low", pa_o, 0);
    settle = 1; step(1); settle = 0; check("R3 pa on", pa_o, 1);

    // R10 command in TX ignored
    send(8'h10); check("R10 count", count_o, 1); check("R10 chan", chan_o, 3);

    // R7/R8 fail-safe
    lol = 1; step(1); lol = 0; check("R8 lol set", status_o[0], 1); check("R7 pa off", pa_o, 0);
    step(4); check("R8 sticky", status_o[0], 1);
    fs_dis = 1; step(1); check("R7 disable", pa_o, 1);
    vco = 1; clr = 1; step(1); vco = 0; clr = 0;
    check("R8 set wins", status_o[1], 1); check("R8 lol clr", status_o[0], 0);
    clr = 1; step(1); clr = 0; fs_dis = 0; step(1); check("R7 clean", pa_o, 1);
    amp = 1; step(1); check("R6 amp", status_o[3], 1);

    // R11 stop bit clear: stays in TX
    en = 0; step(2); check("R11 stay", mode_o, 3); check("R11 pa", pa_o, 1);

    // R11 stop bit set, R9 undervoltage cleared by power-down
    do_reset();
    to_stby();
    send(8'h22); check("R5 count1", count_o, 1);
    uv = 1; step(1); uv = 0; check("R9 uv set", status_o[2], 1);
    en = 0; step(1); check("R11 to stby", mode_o, 2);
    step(1); check("R1 to pd", mode_o, 0);
    uv = 1; step(1); uv = 0; check("R9 uv clear in pd", status_o[2], 0);

    // R5 wrap
    en = 1; step(1); pll_en = 1; osc_rdy = 1; step(1); osc_rdy = 0;
    for (int k = 0; k < 16; k++) begin
      send(8'h02); en = 0; step(1); en = 1; pll_en = 1; step(1);
      if (mode_o == 0) begin osc_rdy = 1; step(2); osc_rdy = 0; end
      else if (mode_o == 1) begin osc_rdy = 1; step(1); osc_rdy = 0; end
    end
    check("R5 wrap", count_o, 1);

    // random phase
    do_reset();
    for (int k = 0; k < 6000; k++) begin
      step(1);
      en      = ($urandom % 16) != 0;
      pll_en  = ($urandom % 8) != 0;
      osc_rdy = $urandom % 2;
      settle  = ($urandom % 4) == 0;
      cmd_v   = ($urandom % 4) == 0;
      cmd     = ($urandom % 3 == 0) ? 8'($urandom) : {2'b00, 6'($urandom | 1)};
      fs_dis  = ($urandom % 8) == 0;
      clr     = ($urandom % 6) == 0;
      lol     = ($urandom % 40) == 0;
      vco     = ($urandom % 40) == 0;
      uv      = ($urandom % 40) == 0;
      amp     = $urandom % 2;
    end
    step(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule